// File: doc/BRIEF.md
# Add/Subtract Unit with Unified Carry-Borrow Flag

This block is a purely combinational unsigned adder/subtractor of parameterised width (8 bits by default). A single mode input chooses the operation. With mode low it forms `a + b`. With mode high it forms `a - b`. Subtraction adds the two's complement of `b`: every bit of `b` is inverted, and the mode bit enters the lowest stage as a carry-in to supply the extra one.

The result wraps modulo 2^W. A single flag output reports whether the next more significant word would need a carry (on add) or a borrow (on subtract). The flag is active high in both modes. In subtract mode the raw carry out of the adder chain is high when no borrow occurs, so the block inverts it in that mode before driving the flag.

Top module: `addsub_flag`

## Requirements
- R1: With `sub` = 0, `sum` equals (`a` + `b`) modulo 2^W.
- R2: With `sub` = 1, `sum` equals (`a` - `b`) modulo 2^W.
- R3: With `sub` = 0, `cb` is 1 exactly when the unsigned sum `a` + `b` is at least 2^W.
- R4: With `sub` = 1, `cb` is 1 exactly when `b` is greater than `a` as unsigned values, which means a borrow is needed. It is 0 when `a` equals `b`.
- R5: At W = 4, 0110 - 0101 gives `sum` 0001 with `cb` 0, and 0101 - 0110 gives `sum` 1111 with `cb` 1.
- R6: The outputs depend only on the present inputs. There is no clock and no stored state, and a new input is reflected within the same cycle.
- R7: With `b` = 0, `sum` equals `a` and `cb` is 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand (minuend when subtracting) |
| b | input | W | Second operand (subtrahend when subtracting) |
| sub | input | 1 | Operation select: 0 add, 1 subtract |
| sum | output | W | Result modulo 2^W |
| cb | output | 1 | Carry (add) or borrow (subtract) into the next word, active high |

## Verification
The hardest case to reach is subtraction with `b` = 0. The inverted operand is then all ones, and the forced carry-in ripples through every stage. The raw carry-out is 1 in this case, and the flag has to turn it into "no borrow". A near-miss in the inversion logic shows up only here and at the `a` = `b` boundary. At 4 bits the bench covers every operand pair in both modes, so these cases and every full-length carry run are all visited. At 8 bits it adds random vectors on top of explicit all-zeros, all-ones, equal-operand and off-by-one pairs.

// File: rtl/addsub_flag.sv
module addsub_flag #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cb
);

  logic [W-1:0] b_eff;
  logic [W:0]   c;

  assign b_eff = b ^ {W{sub}};
  assign c[0]  = sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p;
    assign p        = a[i] ^ b_eff[i];
    assign sum[i]   = p ^ c[i];
    assign c[i+1]   = (a[i] & b_eff[i]) | (p & c[i]);
  end

  assign cb = c[W] ^ sub;

endmodule

// File: rtl/addsub_flag_chk.sv
module addsub_flag_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         sub,
  input logic [W-1:0] sum,
  input logic         cb
);

  logic [W:0] wide_add;
  logic [W-1:0] diff;

  assign wide_add = {1'b0, a} + {1'b0, b};
  assign diff     = a - b;

  always_comb begin
    if (!sub) begin
      // R1
      add_sum_chk: assert (sum == wide_add[W-1:0]) else $error("add result mismatch");
      // R3
      add_carry_chk: assert (cb == wide_add[W]) else $error("add carry mismatch");
    end else begin
      // R2
      sub_diff_chk: assert (sum == diff) else $error("sub result mismatch");
      // R4
      sub_borrow_chk: assert (cb == (b > a)) else $error("sub borrow mismatch");
    end
    // R7
    zero_operand_chk: assert (b != '0 || (sum == a && !cb)) else $error("zero operand not neutral");
  end

endmodule

bind addsub_flag addsub_flag_chk #(.W(W)) u_chk (
  .a(a), .b(b), .sub(sub), .sum(sum), .cb(cb)
);

// File: tb/tb_addsub_flag.sv
module tb_addsub_flag;

  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    logic       s;
    string      req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] a8, b8, sum8;
  logic [3:0] sum4;
  logic       s8, cb8, cb4;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t q[$];

  addsub_flag #(.W(8)) dut  (.a(a8), .b(b8), .sub(s8), .sum(sum8), .cb(cb8));
  addsub_flag #(.W(4)) dut4 (.a(a8[3:0]), .b(b8[3:0]), .sub(s8), .sum(sum4), .cb(cb4));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] a, logic [7:0] b, logic s, string req);
    item_t it;
    @(posedge clk);
    a8 = a; b8 = b; s8 = s;
    it.a = a; it.b = b; it.s = s; it.req = req;
    q.push_back(it);
  endtask

  // monitor: outputs settle in the same cycle (R6), sample at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        int ea, eb, r8, r4, a4, b4;
        it = q.pop_front();
        ea = it.a; eb = it.b; a4 = ea % 16; b4 = eb % 16;
        if (!it.s) begin
          r8 = ea + eb; r4 = a4 + b4;
          check({it.req, " R1 sum8"}, sum8, r8 % 256);
          check({it.req, " R3 cb8"},  cb8,  (r8 >= 256) ? 1 : 0);
          check({it.req, " R1 sum4"}, sum4, r4 % 16);
          check({it.req, " R3 cb4"},  cb4,  (r4 >= 16) ? 1 : 0);
        end else begin
          r8 = ea - eb + 256; r4 = a4 - b4 + 16;
          check({it.req, " R2 sum8"}, sum8, r8 % 256);
          check({it.req, " R4 cb8"},  cb8,  (eb > ea) ? 1 : 0);
          check({it.req, " R2 sum4"}, sum4, r4 % 16);
          check({it.req, " R4 cb4"},  cb4,  (b4 > a4) ? 1 : 0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    a8 = '0; b8 = '0; s8 = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 reset-time sum", sum8, 0);
    check("R7 reset-time cb", cb8, 0);
    rst_n = 1'b1;

    drive(8'h06, 8'h05, 1'b1, "R5");
    drive(8'h05, 8'h06, 1'b1, "R5");
    @(negedge clk);
    @(negedge clk);
    check("R5 last sum4", sum4, 15);
    check("R5 last cb4", cb4, 1);

    for (int s = 0; s < 2; s++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          drive(8'(x), 8'(y), s[0], "exh4");

    drive(8'h00, 8'h00, 1'b1, "R7");
    drive(8'hFF, 8'h00, 1'b1, "R7");
    drive(8'h5A, 8'h00, 1'b0, "R7");
    drive(8'hFF, 8'hFF, 1'b0, "edge");
    drive(8'hFF, 8'h01, 1'b0, "edge");
    drive(8'h80, 8'h80, 1'b1, "edge");
    drive(8'h00, 8'h01, 1'b1, "edge");
    drive(8'h00, 8'hFF, 1'b1, "edge");
    drive(8'h7F, 8'h80, 1'b1, "edge");

    for (int i = 0; i < 3000; i++)
      drive(8'($urandom), 8'($urandom), 1'($urandom), "rand8");

    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule